// File: doc/BRIEF.md
# E1 Receive Slip Buffer

This block moves received E1 timeslot bytes from the recovered line clock into the system clock domain. It holds two frames of 32 timeslots. The line side writes one byte per strobe, and a frame-start mark pins that byte to timeslot 0 of a frame. The system side pulls one byte per read strobe. Under- and overrun are absorbed by slipping a whole frame, and a one-cycle pulse reports each slip.

Two level-style control bits act as one-shot commands on their rising edges. The recentre command sets the store to a depth of one full frame and gives up whatever was queued. The align command acts only when the buffered amount has fallen below half a frame, and then sets it to exactly half a frame. A 5-bit timeslot selector picks one timeslot. The most recent byte read from that timeslot is held on a monitor output.

Top module: `e1_rx_slip_buffer`

## Requirements
- R1: A byte written with the frame-start mark lands in timeslot 0 of a frame, and later bytes take consecutive slots. With matched write and read rates, reads return the bytes in written order with no slip.
- R2: A rising edge on `align_ctl` while at least 16 bytes are buffered changes nothing, and the next read returns the next byte in order.
- R3: A rising edge on `align_ctl` while fewer than 16 bytes are buffered leaves exactly 16 bytes buffered. The next read returns the byte 16 positions behind the newest written byte.
- R4: Holding `align_ctl` high does not act again. A further align needs the bit to be cleared and set.
- R5: A rising edge on `recentre_ctl` leaves exactly 32 bytes buffered, and the next read returns the byte 32 behind the newest written. Holding the bit high has no further effect.
- R6: A read with no unread byte rewinds one frame and returns the byte 32 positions back. `slip_pulse` is high for that one read.
- R7: A read while 63 bytes are buffered skips ahead one frame and returns the byte 32 positions ahead of the read position. `slip_pulse` is high for that one read.
- R8: `mon_byte` holds the byte most recently read from the timeslot equal to `mon_sel`. Bit 4 of `mon_sel` is the MSB, and the timeslot is the low 5 bits of the buffer address.
- R9: After reset, `sys_byte`, `sys_byte_vld`, `slip_pulse` and `mon_byte` are all 0.
- R10: A read strobe in the same system cycle as a command edge is dropped, and `sys_byte_vld` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| line_clk | input | 1 | Recovered line clock |
| line_rst_n | input | 1 | Active-low async reset, line domain |
| rx_byte_en | input | 1 | Write strobe for one received byte |
| rx_frame_start | input | 1 | Marks the strobed byte as timeslot 0 |
| rx_byte | input | 8 | Received timeslot byte |
| sys_clk | input | 1 | System clock |
| sys_rst_n | input | 1 | Active-low async reset, system domain |
| sys_rd_en | input | 1 | Read strobe for one byte |
| align_ctl | input | 1 | Align command bit, rising-edge triggered |
| recentre_ctl | input | 1 | Recentre command bit, rising-edge triggered |
| mon_sel | input | 5 | Timeslot chosen for the monitor |
| sys_byte | output | 8 | Byte read, registered |
| sys_byte_vld | output | 1 | sys_byte updated this cycle |
| slip_pulse | output | 1 | One-cycle pulse on a frame slip |
| mon_byte | output | 8 | Last byte read from the selected timeslot |

## Verification
The bench stops the writer and lets the pointers settle, so that the exact offsets after recentre and align can be predicted. A store that aligned while already deep, or that aligned again on a held bit, would break the byte sequence. A store that recentred to the wrong depth would return a byte at the wrong offset. The underrun and overrun reads are set up to land on exactly 0 and 63 buffered bytes, so a wrong threshold or slip direction returns a different byte or misses the pulse. A read issued in the same cycle as a command, and a long rate-matched stream, check the dropped-read rule and slip-free transport.

// File: rtl/e1es_pkg.sv
package e1es_pkg;
   typedef enum logic [2:0] {
      ACT_NONE,
      ACT_READ,
      ACT_UNDER,
      ACT_OVER,
      ACT_RECENTRE,
      ACT_ALIGN
   } rd_act_e;
endpackage

// File: rtl/e1es_wr_ptr.sv
module e1es_wr_ptr #(
   parameter int PW = 6,
   parameter int SW = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          byte_en,
   input  logic          frame_start,
   output logic [PW-1:0] wr_addr,
   output logic [PW-1:0] ptr_gray
);
   logic [PW-1:0] wp;
   logic [PW-1:0] wp_nxt;

   // a frame-start byte goes to slot 0: stay if already there, else round up
   always_comb begin
      wr_addr = wp;
      if (frame_start && (wp[SW-1:0] != '0))
         wr_addr = {wp[PW-1:SW] + 1'b1, {SW{1'b0}}};
      wp_nxt = wr_addr + PW'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp       <= '0;
         ptr_gray <= '0;
      end else if (byte_en) begin
         wp       <= wp_nxt;
         ptr_gray <= wp_nxt ^ (wp_nxt >> 1);
      end
   end

   // R1: frame-start byte occupies slot 0, so the pointer then sits at slot 1
   p_fs_slot0_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_en && frame_start) |=> (wp[SW-1:0] == SW'(1)));
endmodule

// File: rtl/e1es_gray_sync.sv
module e1es_gray_sync #(
   parameter int W      = 6,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] gray_in,
   output logic [W-1:0] bin_out
);
   logic [W-1:0] stg [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            stg[s] <= '0;
         else if (s == 0)
            stg[s] <= gray_in;
         else
            stg[s] <= stg[(s == 0) ? 0 : s-1];
      end
   end

   always_comb begin
      for (int i = 0; i < W; i++)
         bin_out[i] = ^(stg[STAGES-1] >> i);
   end
endmodule

// File: rtl/e1es_dpram.sv
module e1es_dpram #(
   parameter int AW = 6,
   parameter int DW = 8
) (
   input  logic          wr_clk,
   input  logic          we,
   input  logic [AW-1:0] wa,
   input  logic [DW-1:0] wd,
   input  logic [AW-1:0] ra,
   output logic [DW-1:0] rd
);
   localparam int DEPTH = 1 << AW;
   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge wr_clk) begin
      if (we) mem[wa] <= wd;
   end

   assign rd = mem[ra];
endmodule

// File: rtl/e1es_rd_ctrl.sv
module e1es_rd_ctrl
   import e1es_pkg::*;
#(
   parameter int PW     = 6,
   parameter int SLOTS  = 32,
   parameter int FRAMES = 2,
   parameter int DW     = 8,
   parameter int MON_EN = 1,
   localparam int SW    = $clog2(SLOTS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rd_en,
   input  logic          align_ctl,
   input  logic          recentre_ctl,
   input  logic [SW-1:0] mon_sel,
   input  logic [PW-1:0] wr_ptr_sys,
   input  logic [DW-1:0] mem_word,
   output logic [PW-1:0] mem_addr,
   output logic [DW-1:0] rd_data,
   output logic          rd_vld,
   output logic          slip,
   output logic [DW-1:0] mon_data
);
   localparam logic [PW-1:0] FRAME_C = PW'(SLOTS);
   localparam logic [PW-1:0] HALF_C  = PW'(SLOTS / 2);
   localparam logic [PW-1:0] FULL_C  = PW'(SLOTS * FRAMES - 1);

   logic          align_q, recentre_q;
   logic          align_rise, recentre_rise;
   logic [PW-1:0] rp, rp_nxt, gap, addr;
   logic          fire;
   rd_act_e       act;

   assign align_rise    = align_ctl & ~align_q;
   assign recentre_rise = recentre_ctl & ~recentre_q;
   assign gap           = wr_ptr_sys - rp;

   always_comb begin
      act    = ACT_NONE;
      addr   = rp;
      rp_nxt = rp;
      if (recentre_rise) begin
         act    = ACT_RECENTRE;
         rp_nxt = wr_ptr_sys - FRAME_C;
      end else if (align_rise) begin
         act = ACT_ALIGN;
         if (gap < HALF_C) rp_nxt = wr_ptr_sys - HALF_C;
      end else if (rd_en) begin
         if (gap == '0) begin
            act  = ACT_UNDER;
            addr = rp - FRAME_C;
         end else if (gap >= FULL_C) begin
            act  = ACT_OVER;
            addr = rp + FRAME_C;
         end else begin
            act = ACT_READ;
         end
         rp_nxt = addr + PW'(1);
      end
   end

   assign fire     = (act == ACT_READ) || (act == ACT_UNDER) || (act == ACT_OVER);
   assign mem_addr = addr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         align_q    <= 1'b0;
         recentre_q <= 1'b0;
         rp         <= '0;
         rd_vld     <= 1'b0;
         slip       <= 1'b0;
         rd_data    <= '0;
      end else begin
         align_q    <= align_ctl;
         recentre_q <= recentre_ctl;
         rp         <= rp_nxt;
         rd_vld     <= fire;
         slip       <= (act == ACT_UNDER) || (act == ACT_OVER);
         if (fire) rd_data <= mem_word;
      end
   end

   if (MON_EN != 0) begin : g_mon
      logic          hit;
      logic [DW-1:0] mon_q;
      assign hit = fire && (addr[SW-1:0] == mon_sel);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   mon_q <= '0;
         else if (hit) mon_q <= mem_word;
      end
      assign mon_data = mon_q;

      // R8: monitor changes only after a read of the selected slot
      p_mon_on_match_r8: assert property (@(posedge clk) disable iff (!rst_n)
         !$stable(mon_q) |-> $past(hit));
   end else begin : g_nomon
      assign mon_data = '0;
   end

   // R5: recentre leaves one frame buffered
   p_recentre_depth_r5: assert property (@(posedge clk) disable iff (!rst_n)
      recentre_rise |=> (rp == $past(wr_ptr_sys - FRAME_C)));
   // R3: align below half frame sets exactly half frame
   p_align_exact_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (align_rise && !recentre_rise && gap < HALF_C) |=> (rp == $past(wr_ptr_sys - HALF_C)));
   // R2: align at or above half frame leaves the read pointer alone
   p_align_noop_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (align_rise && !recentre_rise && gap >= HALF_C) |=> $stable(rp));
   // R10: a command cycle never produces read data
   p_cmd_drops_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (align_rise || recentre_rise) |=> !rd_vld);
   // R6: underrun read rewinds one frame
   p_under_rewind_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !align_rise && !recentre_rise && gap == '0) |=> (rp == $past(rp - FRAME_C + PW'(1))));
   // R7: slip pulse lasts one cycle
   p_slip_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
      slip |=> !slip);
endmodule

// File: rtl/e1_rx_slip_buffer.sv
module e1_rx_slip_buffer #(
   parameter int SLOTS       = 32,
   parameter int FRAMES      = 2,
   parameter int BYTE_W      = 8,
   parameter int SYNC_STAGES = 2,
   parameter int MON_EN      = 1,
   localparam int SW         = $clog2(SLOTS),
   localparam int PW         = $clog2(SLOTS * FRAMES)
) (
   input  logic              line_clk,
   input  logic              line_rst_n,
   input  logic              rx_byte_en,
   input  logic              rx_frame_start,
   input  logic [BYTE_W-1:0] rx_byte,
   input  logic              sys_clk,
   input  logic              sys_rst_n,
   input  logic              sys_rd_en,
   input  logic              align_ctl,
   input  logic              recentre_ctl,
   input  logic [SW-1:0]     mon_sel,
   output logic [BYTE_W-1:0] sys_byte,
   output logic              sys_byte_vld,
   output logic              slip_pulse,
   output logic [BYTE_W-1:0] mon_byte
);
   if ((SLOTS < 4) || ((SLOTS & (SLOTS - 1)) != 0)) begin : g_bad_slots
      $error("SLOTS must be a power of two of at least 4");
   end
   if ((FRAMES < 2) || ((FRAMES & (FRAMES - 1)) != 0)) begin : g_bad_frames
      $error("FRAMES must be a power of two of at least 2");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic [PW-1:0]     wr_addr, wr_gray, wr_ptr_sys, rd_addr;
   logic [BYTE_W-1:0] rd_word;

   e1es_wr_ptr #(.PW(PW), .SW(SW)) wr_ptr_i (
      .clk         (line_clk),
      .rst_n       (line_rst_n),
      .byte_en     (rx_byte_en),
      .frame_start (rx_frame_start),
      .wr_addr     (wr_addr),
      .ptr_gray    (wr_gray)
   );

   e1es_gray_sync #(.W(PW), .STAGES(SYNC_STAGES)) sync_i (
      .clk     (sys_clk),
      .rst_n   (sys_rst_n),
      .gray_in (wr_gray),
      .bin_out (wr_ptr_sys)
   );

   e1es_dpram #(.AW(PW), .DW(BYTE_W)) ram_i (
      .wr_clk (line_clk),
      .we     (rx_byte_en),
      .wa     (wr_addr),
      .wd     (rx_byte),
      .ra     (rd_addr),
      .rd     (rd_word)
   );

   e1es_rd_ctrl #(
      .PW(PW), .SLOTS(SLOTS), .FRAMES(FRAMES), .DW(BYTE_W), .MON_EN(MON_EN)
   ) rd_i (
      .clk          (sys_clk),
      .rst_n        (sys_rst_n),
      .rd_en        (sys_rd_en),
      .align_ctl    (align_ctl),
      .recentre_ctl (recentre_ctl),
      .mon_sel      (mon_sel),
      .wr_ptr_sys   (wr_ptr_sys),
      .mem_word     (rd_word),
      .mem_addr     (rd_addr),
      .rd_data      (sys_byte),
      .rd_vld       (sys_byte_vld),
      .slip         (slip_pulse),
      .mon_data     (mon_byte)
   );
endmodule

// File: tb/e1_rx_slip_buffer_tb_top.sv
module e1_rx_slip_buffer_tb_top;
   logic       line_clk = 0, sys_clk = 0;
   logic       line_rst_n = 0, sys_rst_n = 0;
   logic       rx_byte_en = 0, rx_frame_start = 0;
   logic [7:0] rx_byte = '0;
   logic       sys_rd_en = 0, align_ctl = 0, recentre_ctl = 0;
   logic [4:0] mon_sel = '0;
   logic [7:0] sys_byte, mon_byte;
   logic       sys_byte_vld, slip_pulse;

   always #2.5 line_clk = ~line_clk;
   always #2   sys_clk  = ~sys_clk;   // 250 MHz

   e1_rx_slip_buffer dut_i (
      .line_clk(line_clk), .line_rst_n(line_rst_n), .rx_byte_en(rx_byte_en),
      .rx_frame_start(rx_frame_start), .rx_byte(rx_byte), .sys_clk(sys_clk),
      .sys_rst_n(sys_rst_n), .sys_rd_en(sys_rd_en), .align_ctl(align_ctl),
      .recentre_ctl(recentre_ctl), .mon_sel(mon_sel), .sys_byte(sys_byte),
      .sys_byte_vld(sys_byte_vld), .slip_pulse(slip_pulse), .mon_byte(mon_byte)
   );

   int    checks = 0, failures = 0, wcount = 0, slip_cnt = 0, w0 = 0;
   int    exp_q[$];
   string req_q[$];
   int    last_by_slot [32];
   bit    done = 0;
   int    e;
   string r;

   function automatic int m8(input int x);
      return ((x % 256) + 256) % 256;
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int expv);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
      end
   endtask

   task automatic write_bytes(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge line_clk);
         rx_byte_en     = 1;
         rx_byte        = 8'(wcount);
         rx_frame_start = (wcount % 32 == 0);
         @(negedge line_clk);
         rx_byte_en     = 0;
         rx_frame_start = 0;
         wcount++;
         repeat (2) @(negedge line_clk);
      end
   endtask

   task automatic do_read(input int expv, input string req);
      @(negedge sys_clk);
      sys_rd_en = 1;
      exp_q.push_back(expv);
      req_q.push_back(req);
      @(negedge sys_clk);
      sys_rd_en = 0;
      repeat (3) @(negedge sys_clk);
   endtask

   task automatic settle();
      repeat (20) @(negedge sys_clk);
   endtask

   // scoreboard monitor
   always @(negedge sys_clk) begin
      if (sys_rst_n && sys_byte_vld) begin
         if (exp_q.size() == 0) begin
            check(0, "R1 unexpected read data", int'(sys_byte), -1);
         end else begin
            e = exp_q.pop_front();
            r = req_q.pop_front();
            if (e >= 0) check(sys_byte == 8'(e), r, int'(sys_byte), e);
         end
         last_by_slot[sys_byte % 32] = int'(sys_byte);
      end
      if (sys_rst_n && slip_pulse) slip_cnt++;
   end

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
   endtask

   initial begin
      repeat (150000) @(posedge sys_clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
         summary();
         $finish;
      end
   end

   initial begin
      repeat (6) @(negedge sys_clk);
      line_rst_n = 1;
      sys_rst_n  = 1;
      @(negedge sys_clk);
      // R9 reset state
      check(sys_byte == 0,     "R9 sys_byte after reset", int'(sys_byte), 0);
      check(sys_byte_vld == 0, "R9 vld after reset", int'(sys_byte_vld), 0);
      check(slip_pulse == 0,   "R9 slip after reset", int'(slip_pulse), 0);
      check(mon_byte == 0,     "R9 mon after reset", int'(mon_byte), 0);

      mon_sel = 5'd19;
      write_bytes(40);
      settle();
      w0 = wcount;

      // R10: read in the command cycle is dropped; R5: recentre
      @(negedge sys_clk);
      recentre_ctl = 1;
      sys_rd_en    = 1;
      @(negedge sys_clk);
      sys_rd_en = 0;
      check(sys_byte_vld == 0, "R10 read dropped in command cycle", int'(sys_byte_vld), 0);
      do_read(m8(w0 - 32), "R5 recentre depth one frame");
      for (int i = 1; i < 12; i++) do_read(m8(w0 - 32 + i), "R5 recentre held has no effect");
      recentre_ctl = 0;

      // R2: align with 20 buffered is a no-op; keep the bit high
      @(negedge sys_clk);
      align_ctl = 1;
      do_read(m8(w0 - 20), "R2 align no-op when deep");
      for (int i = 19; i >= 15; i--) do_read(m8(w0 - i), "R2 sequence after no-op");
      // R4: now 14 buffered but bit still held
      do_read(m8(w0 - 14), "R4 held align does nothing");

      // R3: clear and set again with 13 buffered
      @(negedge sys_clk);
      align_ctl = 0;
      repeat (2) @(negedge sys_clk);
      align_ctl = 1;
      do_read(m8(w0 - 16), "R3 align to half frame");
      for (int i = 15; i >= 1; i--) do_read(m8(w0 - i), "R3 sequence after align");
      align_ctl = 0;
      settle();
      check(slip_cnt == 0, "R6 no slip before underrun", slip_cnt, 0);

      // R6: underrun
      do_read(m8(w0 - 32), "R6 underrun rewinds one frame");
      settle();
      check(slip_cnt == 1, "R6 slip pulse on underrun", slip_cnt, 1);

      // R7: overrun with 63 buffered
      write_bytes(32);
      settle();
      do_read(m8(w0 + 1), "R7 overrun skips one frame");
      settle();
      check(slip_cnt == 2, "R7 slip pulse on overrun", slip_cnt, 2);
      check(mon_byte == 8'(last_by_slot[19]), "R8 monitor slot 19",
            int'(mon_byte), last_by_slot[19]);
      check(mon_byte % 32 == 19, "R8 monitor byte slot", int'(mon_byte % 32), 19);

      // R1: rate-matched stream after recentre
      mon_sel = 5'd0;
      w0 = wcount;
      @(negedge sys_clk);
      recentre_ctl = 1;
      do_read(m8(w0 - 32), "R5 second recentre");
      recentre_ctl = 0;
      fork
         write_bytes(100);
         for (int i = 0; i < 100; i++) do_read(m8(w0 - 31 + i), "R1 in-order stream");
      join
      settle();
      check(slip_cnt == 2, "R1 no slip in matched stream", slip_cnt, 2);
      check(mon_byte == 8'(last_by_slot[0]), "R8 monitor slot 0",
            int'(mon_byte), last_by_slot[0]);
      check(exp_q.size() == 0, "R1 all reads returned", exp_q.size(), 0);

      done = 1;
      summary();
      $finish;
   end
endmodule